// File: doc/BRIEF.md
# Timer buffer status logic

This block holds the double-buffered period and compare/capture registers of a timer/counter, along with the status byte that reports their state. Software writes new values into buffer registers. The value moves into the live (active) register only when the counter signals its UPDATE condition, and only if update locking is off. Each buffer has a valid flag in the status byte, so software can see whether a pending value is still waiting to be taken.

Each compare/capture channel can run as a compare channel or as a capture channel, selected per channel.
- **Compare channel:** the buffer is filled by bus writes and drained by UPDATE.
- **Capture channel:** the buffer is filled by capture events and drained when software reads the active register.

The block also keeps a stop flag (1 = counter halted) and a client flag. The client flag marks an odd-numbered instance that is chained to its host for 32-bit counting. The counter datapath, waveform output and interrupts sit outside this block.

Top module: `tmr_buf_status`

## Requirements
- R1: After reset the status byte reads 0x01, and every active and buffer register holds zero.
- R2: Status bit positions are fixed: bit 5 = channel 1 buffer valid, bit 4 = channel 0 buffer valid, bit 3 = period buffer valid, bit 1 = client, bit 0 = stop. Bits 7, 6 and 2 read 0.
- R3: A bus write to the period buffer, or to the buffer of a channel in compare mode, stores the data and sets that buffer's valid flag on the next cycle.
- R4: On a cycle with `update` high and `lock_upd` low, each compare or period buffer whose flag is set is copied into its active register and its flag clears. The matching `xfer_*` output is high during the one cycle in which the new active value first appears.
- R5: While `lock_upd` is high, `update` moves no value and leaves every valid flag unchanged.
- R6: A status write with a 1 in bit 3, 4 or 5 clears that period or compare flag, but only while `lock_upd` is high. Zero bits, writes while unlocked, and bits 1 and 0 have no effect.
- R7: When a set event and a clear event hit the same flag in the same cycle, the flag ends set and the newly arrived value is kept in the buffer.
- R8: For a channel in capture mode (`cc_cap_mode` bit = 1), `cap_evt` stores `cap_data` into the buffer and sets the flag. In this mode, bus buffer writes, `update` and status-write clears are ignored for that channel.
- R9: For a capture channel, `cc_rd` with the flag set copies the buffer into the active register and clears the flag. `cc_rd` with the flag clear changes nothing.
- R10: The stop flag sets on the next cycle when `tc_enable` is low, when `stop_cmd` is high, or when `ovf_unf` is high while `oneshot` is high. An overflow without `oneshot` does not set it.
- R11: The stop flag clears on the first enabled cycle after a disabled one, or on `retrig_cmd` while enabled. Any set condition in the same cycle wins. Otherwise the flag holds.
- R12: The client flag reads 1 exactly when `is_client` and `host_32bit` were both high on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| per_wr | input | 1 | Period buffer write strobe |
| per_wdata | input | W | Period buffer write data |
| cc_wr | input | NCH | Per-channel buffer write strobes |
| cc_wdata | input | NCH x W | Per-channel buffer write data |
| cc_cap_mode | input | NCH | Per-channel mode, 1 = capture, 0 = compare |
| cap_evt | input | NCH | Per-channel capture event |
| cap_data | input | NCH x W | Per-channel captured counter value |
| cc_rd | input | NCH | Per-channel read strobe of the active register |
| stat_wr | input | 1 | Status byte write strobe |
| stat_wdata | input | 8 | Status byte write data (write-one-to-clear) |
| lock_upd | input | 1 | Lock update control bit |
| update | input | 1 | UPDATE condition from the counter |
| tc_enable | input | 1 | Timer enable |
| stop_cmd | input | 1 | Stop command |
| retrig_cmd | input | 1 | Retrigger command |
| oneshot | input | 1 | One-shot mode enable |
| ovf_unf | input | 1 | Overflow/underflow event |
| is_client | input | 1 | Instance is odd-numbered client |
| host_32bit | input | 1 | Paired host runs in 32-bit mode |
| status | output | 8 | Status byte |
| per_act | output | W | Active period value |
| cc_act | output | NCH x W | Active compare/capture values |
| xfer_per | output | 1 | Period buffer was moved to active |
| xfer_cc | output | NCH | Channel buffer was moved to active |

## Verification
Every flag and register here is one flop deep. A wrong next-state decision is therefore visible at `status`, `per_act` or `cc_act` on the very next cycle, and the bench samples each port then.

Some errors surface later:
- A lost buffer write or a swallowed clear stays hidden while the flag's value happens to match. It shows only once a later UPDATE or capture read moves the stale buffer content into the active register.
- This is why the bench reads back active values after each transfer, not only the flags. This readback also exposes capture-mode writes that should have been ignored.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
    localparam int STAT_W     = 8;
    localparam int STOP_BIT   = 0;
    localparam int CLIENT_BIT = 1;
    localparam int PER_BIT    = 3;
    localparam int CC_BIT0    = 4;
    localparam int MAX_CH     = STAT_W - CC_BIT0 - 2;
endpackage

// File: rtl/tmr_buf_slot.sv
module tmr_buf_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_mode,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    input  logic         cap_evt,
    input  logic [W-1:0] cap_data,
    input  logic         act_rd,
    input  logic         clr_req,
    input  logic         lock_upd,
    input  logic         update,
    output logic [W-1:0] act_o,
    output logic         vld_o,
    output logic         xfer_o
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] act;
        logic         vld;
        logic         xfer;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.xfer = 1'b0;
        if (cap_mode) begin
            if (act_rd && st_q.vld) begin
                st_d.act  = st_q.shadow;
                st_d.vld  = 1'b0;
                st_d.xfer = 1'b1;
            end
            if (cap_evt) begin
                st_d.shadow = cap_data;
                st_d.vld    = 1'b1;
            end
        end else begin
            if (update && !lock_upd && st_q.vld) begin
                st_d.act  = st_q.shadow;
                st_d.vld  = 1'b0;
                st_d.xfer = 1'b1;
            end
            if (clr_req && lock_upd) begin
                st_d.vld = 1'b0;
            end
            if (bus_wr) begin
                st_d.shadow = bus_wdata;
                st_d.vld    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o  = st_q.act;
    assign vld_o  = st_q.vld;
    assign xfer_o = st_q.xfer;

    AST_WR_SETS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !cap_mode) |=> vld_o); // R3
    AST_XFER_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (update && !lock_upd && vld_o && !cap_mode) |=> (xfer_o && act_o == $past(st_q.shadow))); // R4
    AST_LOCK_KEEPS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_upd && !cap_mode) |=> $stable(act_o)); // R5
    AST_NO_CLR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode && !lock_upd && !update) |=> (vld_o == ($past(vld_o) || $past(bus_wr)))); // R6
    AST_CAP_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && cap_evt) |=> (vld_o && st_q.shadow == $past(cap_data))); // R8
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && act_rd && !vld_o) |=> $stable(act_o)); // R9
endmodule

// File: rtl/tmr_run_flag.sv
module tmr_run_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tc_enable,
    input  logic stop_cmd,
    input  logic retrig_cmd,
    input  logic oneshot,
    input  logic ovf_unf,
    input  logic is_client,
    input  logic host_32bit,
    output logic stop_o,
    output logic client_o
);
    typedef struct packed {
        logic stop;
        logic client;
        logic en_prev;
    } run_t;

    run_t rs_d, rs_q;
    logic set_stop;
    logic clr_stop;

    always_comb begin
        set_stop       = !tc_enable || stop_cmd || (ovf_unf && oneshot);
        clr_stop       = tc_enable && (!rs_q.en_prev || retrig_cmd);
        rs_d           = rs_q;
        rs_d.en_prev   = tc_enable;
        rs_d.client    = is_client && host_32bit;
        if (set_stop) begin
            rs_d.stop = 1'b1;
        end else if (clr_stop) begin
            rs_d.stop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '{stop: 1'b1, client: 1'b0, en_prev: 1'b0};
        end else begin
            rs_q <= rs_d;
        end
    end

    assign stop_o   = rs_q.stop;
    assign client_o = rs_q.client;

    AST_STOP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tc_enable || stop_cmd) |=> stop_o); // R10
    AST_STOP_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_unf && oneshot) |=> stop_o); // R10
    AST_STOP_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_enable && retrig_cmd && !stop_cmd && !(ovf_unf && oneshot)) |=> !stop_o); // R11
    AST_CLIENT_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_client |=> !client_o); // R12
endmodule

// File: rtl/tmr_buf_status.sv
module tmr_buf_status #(
    parameter int W   = 16,
    parameter int NCH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    per_wr,
    input  logic [W-1:0]            per_wdata,
    input  logic [NCH-1:0]          cc_wr,
    input  logic [NCH-1:0][W-1:0]   cc_wdata,
    input  logic [NCH-1:0]          cc_cap_mode,
    input  logic [NCH-1:0]          cap_evt,
    input  logic [NCH-1:0][W-1:0]   cap_data,
    input  logic [NCH-1:0]          cc_rd,
    input  logic                    stat_wr,
    input  logic [7:0]              stat_wdata,
    input  logic                    lock_upd,
    input  logic                    update,
    input  logic                    tc_enable,
    input  logic                    stop_cmd,
    input  logic                    retrig_cmd,
    input  logic                    oneshot,
    input  logic                    ovf_unf,
    input  logic                    is_client,
    input  logic                    host_32bit,
    output logic [7:0]              status,
    output logic [W-1:0]            per_act,
    output logic [NCH-1:0][W-1:0]   cc_act,
    output logic                    xfer_per,
    output logic [NCH-1:0]          xfer_cc
);
    import tmr_stat_pkg::*;

    localparam int TOP_CC_BIT = CC_BIT0 + NCH - 1;

    logic           per_vld;
    logic [NCH-1:0] cc_vld;
    logic           stop_f;
    logic           client_f;
    logic           stat_wdata_unused;

    assign stat_wdata_unused = ^{stat_wdata[7:TOP_CC_BIT+1], stat_wdata[PER_BIT-1:0]};

    tmr_buf_slot #(.W(W)) u_per (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_mode  (1'b0),
        .bus_wr    (per_wr),
        .bus_wdata (per_wdata),
        .cap_evt   (1'b0),
        .cap_data  ('0),
        .act_rd    (1'b0),
        .clr_req   (stat_wr && stat_wdata[PER_BIT]),
        .lock_upd  (lock_upd),
        .update    (update),
        .act_o     (per_act),
        .vld_o     (per_vld),
        .xfer_o    (xfer_per)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        tmr_buf_slot #(.W(W)) u_cc (
            .clk       (clk),
            .rst_n     (rst_n),
            .cap_mode  (cc_cap_mode[gi]),
            .bus_wr    (cc_wr[gi]),
            .bus_wdata (cc_wdata[gi]),
            .cap_evt   (cap_evt[gi]),
            .cap_data  (cap_data[gi]),
            .act_rd    (cc_rd[gi]),
            .clr_req   (stat_wr && stat_wdata[CC_BIT0+gi]),
            .lock_upd  (lock_upd),
            .update    (update),
            .act_o     (cc_act[gi]),
            .vld_o     (cc_vld[gi]),
            .xfer_o    (xfer_cc[gi])
        );
    end

    tmr_run_flag u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .tc_enable  (tc_enable),
        .stop_cmd   (stop_cmd),
        .retrig_cmd (retrig_cmd),
        .oneshot    (oneshot),
        .ovf_unf    (ovf_unf),
        .is_client  (is_client),
        .host_32bit (host_32bit),
        .stop_o     (stop_f),
        .client_o   (client_f)
    );

    always_comb begin
        status                      = '0;
        status[STOP_BIT]            = stop_f;
        status[CLIENT_BIT]          = client_f;
        status[PER_BIT]             = per_vld;
        status[TOP_CC_BIT:CC_BIT0]  = cc_vld;
    end

    AST_LOCK_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_upd && !(|cc_cap_mode)) |=> (!xfer_per && xfer_cc == '0)); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |=> status[PER_BIT]); // R7
    AST_STAT_ONE_HOT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_per |-> !status[PER_BIT] || $past(per_wr)); // R4
endmodule

// File: tb/tmr_buf_status_tb.sv
`timescale 1ns/1ps
module tmr_buf_status_tb;
    localparam int W   = 16;
    localparam int NCH = 2;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  per_wr;
    logic [W-1:0]          per_wdata;
    logic [NCH-1:0]        cc_wr;
    logic [NCH-1:0][W-1:0] cc_wdata;
    logic [NCH-1:0]        cc_cap_mode;
    logic [NCH-1:0]        cap_evt;
    logic [NCH-1:0][W-1:0] cap_data;
    logic [NCH-1:0]        cc_rd;
    logic                  stat_wr;
    logic [7:0]            stat_wdata;
    logic                  lock_upd, update, tc_enable, stop_cmd, retrig_cmd;
    logic                  oneshot, ovf_unf, is_client, host_32bit;
    logic [7:0]            status;
    logic [W-1:0]          per_act;
    logic [NCH-1:0][W-1:0] cc_act;
    logic                  xfer_per;
    logic [NCH-1:0]        xfer_cc;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tmr_buf_status #(.W(W), .NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .per_wr(per_wr), .per_wdata(per_wdata),
        .cc_wr(cc_wr), .cc_wdata(cc_wdata), .cc_cap_mode(cc_cap_mode),
        .cap_evt(cap_evt), .cap_data(cap_data), .cc_rd(cc_rd),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .lock_upd(lock_upd),
        .update(update), .tc_enable(tc_enable), .stop_cmd(stop_cmd),
        .retrig_cmd(retrig_cmd), .oneshot(oneshot), .ovf_unf(ovf_unf),
        .is_client(is_client), .host_32bit(host_32bit), .status(status),
        .per_act(per_act), .cc_act(cc_act), .xfer_per(xfer_per), .xfer_cc(xfer_cc)
    );

    typedef struct packed {
        logic       pw;
        logic [7:0] pd;
        logic       cw;
        logic [7:0] cd;
        logic       sw;
        logic [7:0] sd;
        logic       lk;
        logic       up;
        logic       sp;
        logic [7:0] e_st;
        logic [7:0] e_per;
        logic [7:0] e_c0;
    } row_t;

    localparam int NROW = 15;
    localparam row_t TAB [NROW] = '{
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},
        '{1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h08, 8'h00, 8'h00},
        '{1'b0, 8'h00, 1'b1, 8'h22, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h18, 8'h00, 8'h00},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 8'h11, 8'h22},
        '{1'b1, 8'h33, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h08, 8'h11, 8'h22},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h08, 8'h11, 8'h22},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h08, 1'b0, 1'b0, 1'b0, 8'h08, 8'h11, 8'h22},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h08, 1'b1, 1'b0, 1'b0, 8'h00, 8'h11, 8'h22},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 8'h11, 8'h22},
        '{1'b0, 8'h00, 1'b1, 8'h44, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h10, 8'h11, 8'h22},
        '{1'b0, 8'h00, 1'b1, 8'h55, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h10, 8'h11, 8'h44},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 8'h11, 8'h55},
        '{1'b1, 8'h66, 1'b0, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b0, 8'h08, 8'h11, 8'h55},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h09, 8'h11, 8'h55},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h09, 8'h11, 8'h55}
    };

    localparam string RQ [NROW] = '{
        "R11 enable", "R3 per write", "R3 cc write", "R4 update", "R5 lock write",
        "R5 locked update", "R6 unlocked w1c", "R6 locked w1c", "R4 no valid",
        "R7 write+update idle", "R7 write+update xfer", "R4 second update",
        "R7 w1c vs write, R6 bits1-0", "R10 stop cmd", "R11 hold stopped"
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        per_wr = 0; cc_wr = '0; cap_evt = '0; cc_rd = '0; stat_wr = 0;
        stat_wdata = '0; update = 0; stop_cmd = 0; retrig_cmd = 0; ovf_unf = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        idle();
        per_wdata = '0; cc_wdata = '0; cap_data = '0; cc_cap_mode = '0;
        lock_upd = 0; tc_enable = 0; oneshot = 0; is_client = 0; host_32bit = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 status", {24'h0, status}, 32'h01);
        chk("R1 per_act", {16'h0, per_act}, 32'h0);
        chk("R1 cc_act", cc_act, 32'h0);

        tc_enable = 1;
        for (int i = 0; i < NROW; i++) begin
            per_wr = TAB[i].pw; per_wdata = {8'h0, TAB[i].pd};
            cc_wr = {1'b0, TAB[i].cw}; cc_wdata[0] = {8'h0, TAB[i].cd};
            stat_wr = TAB[i].sw; stat_wdata = TAB[i].sd;
            lock_upd = TAB[i].lk; update = TAB[i].up; stop_cmd = TAB[i].sp;
            tick();
            chk({RQ[i], " R2 status"}, {24'h0, status}, {24'h0, TAB[i].e_st});
            chk({RQ[i], " per_act"}, {16'h0, per_act}, {24'h0, TAB[i].e_per});
            chk({RQ[i], " cc0_act"}, {16'h0, cc_act[0]}, {24'h0, TAB[i].e_c0});
        end
        idle(); lock_upd = 0;

        // R11 retrigger clears stop
        retrig_cmd = 1; tick(); idle();
        chk("R11 retrig", {24'h0, status}, 32'h08);
        // R10 overflow without one-shot
        ovf_unf = 1; tick(); idle();
        chk("R10 ovf no oneshot", {24'h0, status}, 32'h08);
        oneshot = 1; ovf_unf = 1; tick(); idle(); oneshot = 0;
        chk("R10 ovf oneshot", {24'h0, status}, 32'h09);
        retrig_cmd = 1; tick(); idle();
        chk("R11 retrig again", {24'h0, status}, 32'h08);
        // R11 set wins over retrigger
        retrig_cmd = 1; stop_cmd = 1; tick(); idle();
        chk("R11 stop beats retrig", {24'h0, status}, 32'h09);
        tc_enable = 0; tick();
        chk("R10 disabled", {24'h0, status}, 32'h09);
        tc_enable = 1; tick();
        chk("R11 enable rise", {24'h0, status}, 32'h08);
        tick();
        chk("R11 stays running", {24'h0, status}, 32'h08);

        // R4 transfer pulse
        update = 1; tick(); idle();
        chk("R4 per_act 66", {16'h0, per_act}, 32'h66);
        chk("R4 xfer_per high", {31'h0, xfer_per}, 32'h1);
        chk("R4 flag clear", {24'h0, status}, 32'h00);
        tick();
        chk("R4 xfer_per low", {31'h0, xfer_per}, 32'h0);

        // R12 client flag
        is_client = 1; host_32bit = 1; tick();
        chk("R12 client set", {24'h0, status}, 32'h02);
        host_32bit = 0; tick();
        chk("R12 host 16-bit", {24'h0, status}, 32'h00);
        is_client = 0; host_32bit = 1; tick(); host_32bit = 0;
        chk("R12 even instance", {24'h0, status}, 32'h00);

        // R8 capture channel 1
        cc_cap_mode = 2'b10;
        cap_evt[1] = 1; cap_data[1] = 16'h0077; tick(); idle();
        chk("R8 capture sets", {24'h0, status}, 32'h20);
        chk("R8 act unchanged", {16'h0, cc_act[1]}, 32'h0);
        cc_wr[1] = 1; cc_wdata[1] = 16'h00AA; tick(); idle();
        chk("R8 bus write ignored flag", {24'h0, status}, 32'h20);
        update = 1; tick(); idle();
        chk("R8 update ignored", {16'h0, cc_act[1]}, 32'h0);
        lock_upd = 1; stat_wr = 1; stat_wdata = 8'h20; tick(); idle(); lock_upd = 0;
        chk("R8 w1c ignored", {24'h0, status}, 32'h20);
        cc_rd[1] = 1; tick(); idle();
        chk("R9 read moves capture", {16'h0, cc_act[1]}, 32'h77);
        chk("R9 read clears flag", {24'h0, status}, 32'h00);
        cap_evt[1] = 1; cap_data[1] = 16'h0088; tick(); idle();
        cap_evt[1] = 1; cap_data[1] = 16'h0099; cc_rd[1] = 1; tick(); idle();
        chk("R7 capture+read act", {16'h0, cc_act[1]}, 32'h88);
        chk("R7 capture+read flag", {24'h0, status}, 32'h20);
        cc_rd[1] = 1; tick(); idle();
        chk("R9 second read", {16'h0, cc_act[1]}, 32'h99);
        cc_rd[1] = 1; tick(); idle();
        chk("R9 empty read", {16'h0, cc_act[1]}, 32'h99);
        chk("R9 empty read flag", {24'h0, status}, 32'h00);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule